// File: doc/BRIEF.md
# Alarm-Triggered Periodic Pulse Generator

This block produces periodic pulse events that stay in phase with a free-running nanosecond time base. It has two absolute-time alarm comparators. When the time base reaches an armed alarm, every idle enabled channel that listens to that alarm starts counting down a programmed interval, which is consumed by the tick increment on each time-base update. Each time the interval runs out, the channel raises a sticky event bit, drives an optional output pulse of programmable width in clock cycles, and reloads. If the interval is programmed to one second minus one tick, the pulses land on whole-second values of the time base.

Software writes an alarm at a future whole second, sets the interval, and enables the channel. Before it steps or retunes the time base, software disables the channel and then re-arms an alarm so that the pulses come back aligned. Events go to a write-1-to-clear status word, and a mask decides which of them raise the registered interrupt.

Top module: `alarm_pulse_gen`

## Requirements
- R1: After reset, both alarm words of each alarm read 0xFFFFFFFF. Every interval register reads 0xFFFFFFFF. The control word reads 0x00808080, with every channel disabled. The event and mask words read 0, and `pulse_out` and `irq` are low.
- R2: Writing the upper alarm word (address 2a+1 for alarm a) arms alarm a, and writing its lower word (address 2a) disarms it. An armed alarm fires on the first update (`time_valid` high) whose `cur_time` is greater than or equal to the alarm value. Firing sets event bit 16+a and disarms the alarm, so it fires only once until its upper word is written again.
- R3: Channel i is configured by control byte i at bits 8i+7..8i. Bit 7 disables the channel. Bit 6 drives the pin. Bit 5 selects the start alarm (0 for alarm 0, 1 for alarm 1). Bits 4..0 hold the pulse width. An enabled idle channel whose selected alarm fires loads its interval register (address 4+i) and starts running. A channel that is already running ignores later alarm firings.
- R4: On every update while it is running, a channel compares its remaining count with `tick_inc`. If the count is smaller, the interval expires and the count reloads from the interval register. Otherwise `tick_inc` is subtracted from the count. With interval S−T and tick T, expiries therefore fall on the updates at alarm time + k·S.
- R5: Each expiry of channel i sets event bit 7−i.
- R6: After an expiry, `pulse_out[i]` is high for exactly PW clock cycles, beginning in the cycle that follows the expiry edge. This happens only when control bit 6 is set. If bit 6 is clear or PW is 0, the pin stays low, but the event bit is still set.
- R7: Setting the disable bit forces `pulse_out[i]` low from the next cycle and discards the running count. A re-enabled channel stays silent until its selected alarm fires again.
- R8: Writing the event word (address 9) clears each bit written as 1 and leaves every bit written as 0 unchanged. Event bits are sticky until they are cleared.
- R9: `irq` is a register that holds the OR of (event AND mask) from the previous cycle. The mask lives at address 10.
- R10: Alarm, interval, and mask registers read back the values last written to them. Addresses with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_valid | input | 1 | Time-base update strobe |
| cur_time | input | 64 | Current time in nanoseconds |
| tick_inc | input | 8 | Integer nanoseconds added per update |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on address |
| pulse_out | output | 3 | Per-channel output pulse |
| irq | output | 1 | Registered masked event interrupt |

## Verification
The bench runs updates with random gaps and checks the first expiry after an alarm, which must fall on alarm + S and not one tick early. A counter that expires at zero instead of below one tick would be caught here. The bench disables a channel while it is running and then re-enables it. A design that resumes counting without a fresh alarm would produce an extra event. The bench re-arms an alarm while a second channel is already running on it, and a design that restarts running channels would move that channel's phase. The bench also lets the time base run well past an alarm that has already fired after clearing its event, so a comparator that retriggers on every later update would set the alarm bit again.

// File: rtl/apg_pkg.sv
package apg_pkg;
   localparam int unsigned REG_AW   = 4;
   localparam int unsigned REG_DW   = 32;
   localparam int unsigned CTRL_PWW = 5;

   localparam logic [REG_AW-1:0] ADR_ALARM_BASE = 4'd0;
   localparam logic [REG_AW-1:0] ADR_IVL_BASE   = 4'd4;
   localparam logic [REG_AW-1:0] ADR_CTRL       = 4'd8;
   localparam logic [REG_AW-1:0] ADR_EVENT      = 4'd9;
   localparam logic [REG_AW-1:0] ADR_MASK       = 4'd10;

   localparam int unsigned EVT_CH_TOP   = 7;
   localparam int unsigned EVT_ALM_BASE = 16;

   typedef struct packed {
      logic                dis;
      logic                pg;
      logic                sel;
      logic [CTRL_PWW-1:0] pw;
   } chan_ctrl_t;

   function automatic logic [REG_DW-1:0] ctrl_reset_value(int unsigned nch);
      logic [REG_DW-1:0] v;
      v = '0;
      for (int i = 0; i < int'(nch); i++) v[8*i+7] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/apg_alarm.sv
module apg_alarm #(
   parameter int unsigned TW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [31:0]   wdata,
   input  logic          time_valid,
   input  logic [TW-1:0] cur_time,
   output logic [TW-1:0] alarm_val,
   output logic          hit
);
   logic [TW-1:0] alm_q;
   logic          armed_q;

   assign hit       = armed_q && time_valid && (cur_time >= alm_q);
   assign alarm_val = alm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_q   <= '1;
         armed_q <= 1'b0;
      end else if (wr_lo) begin
         alm_q[31:0] <= wdata;
         armed_q     <= 1'b0;
      end else if (wr_hi) begin
         alm_q[TW-1:32] <= wdata[TW-33:0];
         armed_q        <= 1'b1;
      end else if (hit) begin
         armed_q <= 1'b0;
      end
   end

   assert_fire_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_hi) |=> !hit);
   assert_lo_disarms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !hit);
endmodule

// File: rtl/apg_channel.sv
module apg_channel #(
   parameter int unsigned IVW   = 32,
   parameter int unsigned TICKW = 8,
   parameter int unsigned PWW   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dis,
   input  logic             pg,
   input  logic [PWW-1:0]   pw,
   input  logic [IVW-1:0]   interval,
   input  logic [TICKW-1:0] tick_inc,
   input  logic             time_valid,
   input  logic             start,
   output logic             expire,
   output logic             pulse
);
   typedef enum logic {CH_IDLE = 1'b0, CH_RUN = 1'b1} ch_state_e;

   ch_state_e      state_q;
   logic [IVW-1:0] rem_q;
   logic [PWW-1:0] wcnt_q;
   logic [IVW-1:0] step;

   assign step   = IVW'(tick_inc);
   assign expire = (state_q == CH_RUN) && time_valid && !dis && (rem_q < step);
   assign pulse  = (wcnt_q != '0) && pg && !dis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         rem_q   <= '0;
         wcnt_q  <= '0;
      end else if (dis) begin
         state_q <= CH_IDLE;
         rem_q   <= '0;
         wcnt_q  <= '0;
      end else begin
         if (state_q == CH_IDLE) begin
            if (start) begin
               state_q <= CH_RUN;
               rem_q   <= interval;
            end
         end else if (time_valid) begin
            rem_q <= expire ? interval : rem_q - step;
         end
         if (expire)              wcnt_q <= pw;
         else if (wcnt_q != '0)   wcnt_q <= wcnt_q - 1'b1;
      end
   end

   assert_reenable_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dis) |-> (state_q == CH_IDLE) && (wcnt_q == '0));
   assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_IDLE && start && !dis) |=> (state_q == CH_RUN) && (rem_q == $past(interval)));
   assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_RUN && time_valid && !dis && !expire) |=> (rem_q == $past(rem_q) - $past(step)));
   assert_pulse_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dis && !expire && wcnt_q != '0) |=> (wcnt_q == $past(wcnt_q) - 1'b1));
endmodule

// File: rtl/apg_events.sv
module apg_events #(
   parameter int unsigned NUM_CH  = 3,
   parameter int unsigned NUM_ALM = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  ch_expire,
   input  logic [NUM_ALM-1:0] alm_hit,
   input  logic               wr_evt,
   input  logic               wr_mask,
   input  logic [31:0]        wdata,
   output logic [31:0]        evt_q,
   output logic [31:0]        mask_q,
   output logic               irq
);
   import apg_pkg::*;

   logic [31:0] set_vec;
   logic        irq_q;

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < int'(NUM_CH); i++)  set_vec[EVT_CH_TOP - i]   = ch_expire[i];
      for (int a = 0; a < int'(NUM_ALM); a++) set_vec[EVT_ALM_BASE + a] = alm_hit[a];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_evt) evt_q <= (evt_q & ~wdata) | set_vec;
         else        evt_q <= evt_q | set_vec;
         if (wr_mask) mask_q <= wdata;
         irq_q <= |(evt_q & mask_q);
      end
   end

   assign irq = irq_q;

   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && ((wdata & ~set_vec & evt_q) != '0)) |=> ((evt_q & $past(wdata & ~set_vec)) == '0));
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
   assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));
   assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_q & mask_q) == '0) |=> !irq);
   assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_q & mask_q) != '0) |=> irq);
endmodule

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen #(
   parameter int unsigned NUM_CH  = 3,
   parameter int unsigned NUM_ALM = 2,
   parameter int unsigned TW      = 64,
   parameter int unsigned IVW     = 32,
   parameter int unsigned TICKW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              time_valid,
   input  logic [TW-1:0]     cur_time,
   input  logic [TICKW-1:0]  tick_inc,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NUM_CH-1:0] pulse_out,
   output logic              irq
);
   import apg_pkg::*;

   localparam int unsigned CTRLW = 8 * NUM_CH;
   localparam logic [CTRLW-1:0] CTRL_RST = CTRLW'(ctrl_reset_value(NUM_CH));

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must be 1 to 4");
   end
   if (NUM_ALM < 1 || NUM_ALM > 2) begin : g_bad_alm
      $error("NUM_ALM must be 1 or 2");
   end
   if (TW < 33 || TW > 64) begin : g_bad_tw
      $error("TW must be 33 to 64");
   end
   if (IVW > 32 || IVW < TICKW) begin : g_bad_ivw
      $error("IVW must be at most 32 and at least TICKW");
   end

   logic [CTRLW-1:0]   ctrl_q;
   logic [IVW-1:0]     ivl_q [NUM_CH];
   logic [TW-1:0]      alm_val [NUM_ALM];
   logic [NUM_ALM-1:0] alm_hit;
   logic [NUM_CH-1:0]  ch_expire;
   logic [31:0]        evt_q, mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_RST;
      else if (reg_wr && reg_addr == ADR_CTRL) ctrl_q <= reg_wdata[CTRLW-1:0];
   end

   for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
      apg_alarm #(.TW(TW)) i_alarm (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_lo      (reg_wr && reg_addr == 4'(ADR_ALARM_BASE + 2*a)),
         .wr_hi      (reg_wr && reg_addr == 4'(ADR_ALARM_BASE + 2*a + 1)),
         .wdata      (reg_wdata),
         .time_valid (time_valid),
         .cur_time   (cur_time),
         .alarm_val  (alm_val[a]),
         .hit        (alm_hit[a])
      );
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_ctrl_t cc;
      logic       start;
      assign cc = ctrl_q[8*i +: 8];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ivl_q[i] <= '1;
         else if (reg_wr && reg_addr == 4'(ADR_IVL_BASE + i)) ivl_q[i] <= reg_wdata[IVW-1:0];
      end

      if (NUM_ALM == 1) begin : g_one_src
         assign start = alm_hit[0];
      end else begin : g_sel_src
         assign start = cc.sel ? alm_hit[1] : alm_hit[0];
      end

      apg_channel #(.IVW(IVW), .TICKW(TICKW), .PWW(CTRL_PWW)) i_channel (
         .clk        (clk),
         .rst_n      (rst_n),
         .dis        (cc.dis),
         .pg         (cc.pg),
         .pw         (cc.pw),
         .interval   (ivl_q[i]),
         .tick_inc   (tick_inc),
         .time_valid (time_valid),
         .start      (start),
         .expire     (ch_expire[i]),
         .pulse      (pulse_out[i])
      );
   end

   apg_events #(.NUM_CH(NUM_CH), .NUM_ALM(NUM_ALM)) i_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_expire (ch_expire),
      .alm_hit   (alm_hit),
      .wr_evt    (reg_wr && reg_addr == ADR_EVENT),
      .wr_mask   (reg_wr && reg_addr == ADR_MASK),
      .wdata     (reg_wdata),
      .evt_q     (evt_q),
      .mask_q    (mask_q),
      .irq       (irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int a = 0; a < int'(NUM_ALM); a++) begin
         if (reg_addr == 4'(ADR_ALARM_BASE + 2*a))     reg_rdata = alm_val[a][31:0];
         if (reg_addr == 4'(ADR_ALARM_BASE + 2*a + 1)) reg_rdata = 32'(alm_val[a][TW-1:32]);
      end
      for (int i = 0; i < int'(NUM_CH); i++) begin
         if (reg_addr == 4'(ADR_IVL_BASE + i)) reg_rdata = 32'(ivl_q[i]);
      end
      if (reg_addr == ADR_CTRL)  reg_rdata = 32'(ctrl_q);
      if (reg_addr == ADR_EVENT) reg_rdata = evt_q;
      if (reg_addr == ADR_MASK)  reg_rdata = mask_q;
   end
endmodule

// File: tb/test_alarm_pulse_gen.sv
module test_alarm_pulse_gen;
   import apg_pkg::*;

   localparam longint unsigned T = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        time_valid = 1'b0;
   logic [63:0] cur_time = '0;
   logic [7:0]  tick_inc = 8'(T);
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = ADR_EVENT;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  pulse_out;
   logic        irq;

   always #10 clk = ~clk;

   alarm_pulse_gen i_alarm_pulse_gen (
      .clk(clk), .rst_n(rst_n), .time_valid(time_valid), .cur_time(cur_time),
      .tick_inc(tick_inc), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pulse_out(pulse_out), .irq(irq)
   );

   int vectors = 0;
   int errors  = 0;

   longint unsigned t_now = 0;
   logic [31:0] m_evt = '0, m_mask = '0;
   logic [63:0] m_alm [2];
   bit          m_armed [2];
   logic [7:0]  cb [3];
   bit          run [3];
   longint unsigned base [3];
   longint unsigned S [3];
   int          pcnt [3];
   logic [31:0] rdv;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit tv, input bit wr, input logic [3:0] a, input logic [31:0] d);
      bit          hit [2];
      bit          ex;
      bit          en;
      bit          irq_e;
      logic [31:0] setv;
      @(negedge clk);
      if (tv) t_now += T;
      time_valid = tv; cur_time = t_now; reg_wr = wr; reg_addr = a; reg_wdata = d;
      irq_e = |(m_evt & m_mask);
      setv = '0;
      for (int k = 0; k < 2; k++) begin
         hit[k] = tv && m_armed[k] && (t_now >= m_alm[k]);
         if (hit[k]) setv[16+k] = 1'b1;
      end
      for (int i = 0; i < 3; i++) begin
         en = !cb[i][7];
         ex = tv && en && run[i] && (t_now > base[i]) && (((t_now - base[i]) % S[i]) == 0);
         if (ex) setv[7-i] = 1'b1;
         if (!en) begin
            run[i] = 1'b0; pcnt[i] = 0;
         end else begin
            if (ex) pcnt[i] = int'(cb[i][4:0]);
            else if (pcnt[i] > 0) pcnt[i]--;
            if (!run[i] && hit[int'(cb[i][5])]) begin
               run[i] = 1'b1; base[i] = t_now;
            end
         end
      end
      if (wr && a == ADR_EVENT) m_evt = (m_evt & ~d) | setv;
      else m_evt = m_evt | setv;
      if (wr && a == ADR_MASK) m_mask = d;
      for (int k = 0; k < 2; k++) begin
         if (wr && a == 4'(2*k)) begin m_alm[k][31:0] = d; m_armed[k] = 1'b0; end
         else if (wr && a == 4'(2*k+1)) begin m_alm[k][63:32] = d; m_armed[k] = 1'b1; end
         else if (hit[k]) m_armed[k] = 1'b0;
      end
      if (wr && a == ADR_CTRL) for (int i = 0; i < 3; i++) cb[i] = d[8*i +: 8];
      @(posedge clk);
      #2;
      for (int i = 0; i < 3; i++)
         chk("R6 R7 pulse_out", 64'(pulse_out[i]), 64'(pcnt[i] > 0 && cb[i][6] && !cb[i][7]));
      chk("R9 irq", 64'(irq), 64'(irq_e));
      if (!wr && a == ADR_EVENT) chk("R2 R3 R4 R5 R8 event word", 64'(reg_rdata), 64'(m_evt));
      rdv = reg_rdata;
   endtask

   task automatic rd(input logic [3:0] a);
      cyc(1'b0, 1'b0, a, '0);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      #(20 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] ctrl_word;
      longint unsigned a2;
      void'($urandom(32'd20250813));
      for (int k = 0; k < 2; k++) begin m_alm[k] = '1; m_armed[k] = 1'b0; end
      for (int i = 0; i < 3; i++) begin cb[i] = 8'h80; run[i] = 1'b0; pcnt[i] = 0; base[i] = 0; S[i] = 100; end

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 pulse_out", 64'(pulse_out), 64'd0);
      chk("R1 irq", 64'(irq), 64'd0);
      for (int a = 0; a < 4; a++) begin rd(4'(a)); chk("R1 alarm word", 64'(rdv), 64'hFFFFFFFF); end
      for (int i = 0; i < 3; i++) begin rd(4'(4+i)); chk("R1 interval", 64'(rdv), 64'hFFFFFFFF); end
      rd(ADR_CTRL);  chk("R1 control", 64'(rdv), 64'h00808080);
      rd(ADR_EVENT); chk("R1 event", 64'(rdv), 64'd0);
      rd(ADR_MASK);  chk("R1 mask", 64'(rdv), 64'd0);

      // R10 readback
      for (int i = 0; i < 3; i++) begin
         v = $urandom; wr(4'(4+i), v); rd(4'(4+i)); chk("R10 interval readback", 64'(rdv), 64'(v));
      end
      v = $urandom; wr(ADR_MASK, v); rd(ADR_MASK); chk("R10 mask readback", 64'(rdv), 64'(v));
      v = $urandom; wr(4'd2, v); rd(4'd2); chk("R10 alarm low readback", 64'(rdv), 64'(v));
      v = $urandom; wr(4'd3, v); rd(4'd3); chk("R10 alarm high readback", 64'(rdv), 64'(v));
      rd(4'd7);  chk("R10 unmapped", 64'(rdv), 64'd0);
      rd(4'd15); chk("R10 unmapped", 64'(rdv), 64'd0);
      wr(4'd2, 32'hFFFFFFFF); wr(4'd3, 32'hFFFFFFFF);

      // setup three channels
      for (int i = 0; i < 3; i++) begin
         S[i] = T * longint'($urandom_range(5, 12));
         wr(4'(4+i), 32'(S[i] - T));
      end
      ctrl_word = '0;
      ctrl_word[7:0]   = {1'b0, 1'b1, 1'b0, 5'($urandom_range(1, 4))};
      ctrl_word[15:8]  = {1'b0, 1'b1, 1'b1, 5'($urandom_range(0, 4))};
      ctrl_word[23:16] = {1'b0, 1'b0, 1'b0, 5'($urandom_range(1, 31))};
      wr(ADR_CTRL, ctrl_word);
      wr(ADR_MASK, 32'h00030080);
      wr(4'd0, 32'd300); wr(4'd1, 32'd0);
      wr(4'd2, 32'd470); wr(4'd3, 32'd0);

      // random run
      for (int n = 0; n < 400; n++) begin
         int r;
         r = int'($urandom % 10);
         if (r < 7)       cyc(1'b1, 1'b0, ADR_EVENT, '0);
         else if (r == 7) wr(ADR_EVENT, $urandom);
         else if (r == 8) wr(ADR_MASK, $urandom & 32'h000300E0);
         else             cyc(1'b0, 1'b0, ADR_EVENT, '0);
      end

      // R7 disable, then re-enable without a fresh alarm
      wr(ADR_CTRL, ctrl_word | 32'h00000080);
      wr(ADR_EVENT, 32'hFFFFFFFF);
      for (int n = 0; n < 40; n++) cyc(1'b1, 1'b0, ADR_EVENT, '0);
      wr(ADR_CTRL, ctrl_word);
      for (int n = 0; n < 60; n++) cyc(1'b1, 1'b0, ADR_EVENT, '0);
      rd(ADR_EVENT);
      chk("R7 re-enabled channel stays silent", 64'(rdv[7]), 64'd0);

      // R3 fresh alarm restarts channel 0; channel 2 keeps its phase
      a2 = t_now + 200;
      wr(4'd0, 32'(a2)); wr(4'd1, 32'(a2 >> 32));
      for (int n = 0; n < 250; n++) begin
         if (($urandom % 10) < 7) cyc(1'b1, 1'b0, ADR_EVENT, '0);
         else                     cyc(1'b0, 1'b0, ADR_EVENT, '0);
      end
      rd(ADR_EVENT);
      chk("R3 channel restarted by new alarm", 64'(rdv[7]), 64'd1);

      // R2 alarm fires once per write
      wr(ADR_EVENT, 32'hFFFFFFFF);
      for (int n = 0; n < 60; n++) cyc(1'b1, 1'b0, ADR_EVENT, '0);
      rd(ADR_EVENT);
      chk("R2 alarms do not retrigger", 64'(rdv[17:16]), 64'd0);

      finish_run();
   end
endmodule